// File: doc/BRIEF.md
# Interrupt Source Pending/Queued State Bank

This block holds a two-bit state for each of a set of interrupt sources. P (pending) means a notification has gone out and has not yet been acknowledged. Q (queued) means another trigger arrived while P was set. The two bits fold any number of repeated triggers into at most one outstanding notification plus one queued retrigger. Because of this, a source can never sit in a downstream queue more than once. Sources are triggered by hardware inputs or by a store to the source's trigger page. Each trigger input is configured at build time as message-style or level-sensitive.

Software manages the state through 8-byte loads to a per-source management page. Every such load returns the old state and applies its update in the same cycle, as one atomic step: end-of-interrupt, a plain read, or a forced value.

Each source owns a page of 2^PAGE_SHIFT bytes at source × 2^PAGE_SHIFT. The region therefore covers 2^PAGE_SHIFT × NUM_SRC bytes. In two-page mode the lower half of each page is the trigger page and the management page starts 2^(PAGE_SHIFT-1) bytes above it. In single-page mode one page serves both roles.

Accesses arrive on a valid/ready request stream and leave on a valid/ready response stream. Notifications leave on a third valid/ready stream that carries the source number.

Top module: `pq_source_bank`

## Requirements
- R1: After reset every source state is 00 (bit 1 = P, bit 0 = Q), notify_valid and rsp_valid are low, and req_ready is high.
- R2: A trigger moves the state as follows:
  - 00 becomes 10 and requests a notification.
  - 10, 01 and 11 all become 11 and request none.
  - State 01 therefore acts as a mask.
- R3: End-of-interrupt clears Q. If Q was 1, the state becomes 10 and a notification is requested. If Q was 0, the state becomes 00.
- R4: On a level-sensitive source, an end-of-interrupt that would leave 00 while its trig_in is still high instead leaves 10 and requests a notification.
- R5: A rising edge on trig_in is one trigger. A store accepted in a source's trigger page is also one trigger. A message source held high is not retriggered by end-of-interrupt.
- R6: Loads in the management page decode address bits [11:10]. 00 is end-of-interrupt, 10 is read-only, 11 forces the state to bits [9:8], and 01 is invalid. Every valid load returns the old state in rsp_data bits [1:0] with all other bits 0.
- R7: In two-page mode, address bit PAGE_SHIFT-1 selects the management half. A load in the trigger half, or a store in the management half, returns all ones and changes nothing.
- R8: An access returns all ones and changes no state if any of these hold:
  - req_size is not 3 (8 bytes);
  - address bits [2:0] are not zero;
  - a load has nonzero bits in [7:3] or between bit 12 and the half-select bit;
  - the source number is NUM_SRC or above.
- R9: Notification stream:
  - notify_valid stays high and notify_src stays stable until notify_ready.
  - Pending sources are served round-robin, starting after the last source served.
  - A second request for a source still waiting is merged into the first.
- R10: Response stream:
  - Each accepted request gives exactly one response one cycle later.
  - req_ready equals !rsp_valid || rsp_ready.
  - rsp_data is held while rsp_valid is high and rsp_ready is low.
- R11: When an access and a hardware trigger reach the same source in the same cycle, the access is applied first and the trigger second.
- R12: An accepted trigger-page store returns 0 in rsp_data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_in | input | NUM_SRC | Hardware trigger lines, one per source |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | PAGE_SHIFT+clog2(NUM_SRC)+1 | Byte address in the source region |
| req_size | input | 2 | log2 of access size in bytes |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | 64 | Old state or all ones |
| notify_valid | output | 1 | Notification valid |
| notify_ready | input | 1 | Notification consumed |
| notify_src | output | clog2(NUM_SRC) | Source being notified |

## Verification
The hardest situations to reach are the collisions. An atomic load and a hardware edge can hit the same source in one cycle. Several sources can be waiting while the notification consumer stalls, so that round-robin order and hold-stable both matter. Directed steps line up a forced-state load with a same-cycle trig_in edge, and drop notify_ready while three sources fire together. A long random phase then drives random ready levels, trigger toggles and decoded and malformed addresses, while a behavioural model is compared every cycle.

// File: rtl/pq_pkg.sv
package pq_pkg;

  // Decoded access kind for one accepted request
  typedef enum logic [2:0] {
    ACC_BAD,
    ACC_TRIG,
    ACC_EOI,
    ACC_READ,
    ACC_SET
  } acc_op_e;

  localparam logic [1:0] PQ_OFF     = 2'b00;
  localparam logic [1:0] PQ_PENDING = 2'b10;
  localparam logic [1:0] PQ_BOTH    = 2'b11;

endpackage

// File: rtl/pq_decode.sv
module pq_decode
  import pq_pkg::*;
#(
  parameter int NUM_SRC    = 8,
  parameter int PAGE_SHIFT = 13,
  parameter bit TWO_PAGE   = 1'b1
) (
  input  logic [PAGE_SHIFT+$clog2(NUM_SRC):0] addr,
  input  logic                                write,
  input  logic [1:0]                          size,
  output logic [$clog2(NUM_SRC)-1:0]          src,
  output acc_op_e                             op,
  output logic [1:0]                          set_val
);
  localparam int IDX_W  = $clog2(NUM_SRC);
  localparam int SRC_W  = IDX_W + 1;
  localparam int ADDR_W = PAGE_SHIFT + SRC_W;
  localparam int MID_HI = TWO_PAGE ? PAGE_SHIFT - 2 : PAGE_SHIFT - 1;

  logic [SRC_W-1:0] src_full;
  logic             src_ok;
  logic             mgmt_sel;
  logic             mid_zero;

  assign src_full = addr[ADDR_W-1:PAGE_SHIFT];
  assign src_ok   = src_full < SRC_W'(NUM_SRC);
  assign src      = src_full[IDX_W-1:0];

  // Page layout variant
  if (TWO_PAGE) begin : g_two
    assign mgmt_sel = addr[PAGE_SHIFT-1];
  end else begin : g_one
    assign mgmt_sel = 1'b1;
  end

  // Reserved offset bits above the op field
  if (MID_HI >= 12) begin : g_mid
    assign mid_zero = (addr[MID_HI:12] == '0);
  end else begin : g_nomid
    assign mid_zero = 1'b1;
  end

  always_comb begin
    op      = ACC_BAD;
    set_val = addr[9:8];
    if (src_ok && size == 2'd3 && addr[2:0] == 3'b000) begin
      if (write) begin
        if (!TWO_PAGE || !mgmt_sel) op = ACC_TRIG;
      end else if (mgmt_sel && mid_zero && addr[7:3] == 5'd0) begin
        case (addr[11:10])
          2'b00:   op = ACC_EOI;
          2'b10:   op = ACC_READ;
          2'b11:   op = ACC_SET;
          default: op = ACC_BAD;
        endcase
      end
    end
  end

endmodule

// File: rtl/pq_cell.sv
module pq_cell
  import pq_pkg::*;
#(
  parameter bit LEVEL = 1'b0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_in,
  input  logic       acc_en,
  input  acc_op_e    acc_op,
  input  logic [1:0] acc_set,
  output logic [1:0] pq,
  output logic       notify_req
);
  logic       hw_q;
  logic       trig;
  logic       n_eoi;
  logic       n_trig;
  logic [1:0] mid;
  logic [1:0] nxt;

  always_comb begin
    // Stage 1: software access
    mid   = pq;
    n_eoi = 1'b0;
    if (acc_en) begin
      case (acc_op)
        ACC_EOI: begin
          if (pq[0] || (LEVEL && hw_in)) begin
            mid   = PQ_PENDING;
            n_eoi = 1'b1;
          end else begin
            mid = PQ_OFF;
          end
        end
        ACC_SET: mid = acc_set;
        default: mid = pq;
      endcase
    end

    // Stage 2: trigger, after the access
    trig   = (hw_in && !hw_q) || (acc_en && acc_op == ACC_TRIG);
    nxt    = mid;
    n_trig = 1'b0;
    if (trig) begin
      if (mid == PQ_OFF) begin
        nxt    = PQ_PENDING;
        n_trig = 1'b1;
      end else begin
        nxt = PQ_BOTH;
      end
    end
    notify_req = n_eoi || n_trig;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pq   <= PQ_OFF;
      hw_q <= 1'b0;
    end else begin
      pq   <= nxt;
      hw_q <= hw_in;
    end
  end

  // A notification always leaves P set
  assert_notify_sets_p_R2: assert property (@(posedge clk) disable iff (!rst_n)
    notify_req |=> pq[1]);

  // Trigger on a busy or masked state stays silent
  assert_masked_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && !acc_en && pq != PQ_OFF) |-> !notify_req);

  // End-of-interrupt without a trigger leaves Q clear
  assert_eoi_clears_q_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_op == ACC_EOI && !trig) |=> !pq[0]);

endmodule

// File: rtl/pq_notify_arb.sv
module pq_notify_arb #(
  parameter int NUM_SRC = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NUM_SRC-1:0]         set_vec,
  input  logic                       ready,
  output logic                       valid,
  output logic [$clog2(NUM_SRC)-1:0] src
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend;
  logic [NUM_SRC-1:0] clr;
  logic [IDX_W-1:0]   ptr;
  logic [IDX_W-1:0]   pick;
  logic [IDX_W-1:0]   lock_idx;
  logic               lock;
  logic               found;
  logic               hs;

  // Round-robin search starting after the last grant
  always_comb begin
    pick  = ptr;
    found = 1'b0;
    for (int k = 1; k <= NUM_SRC; k++) begin
      int idx;
      idx = (int'(ptr) + k) % NUM_SRC;
      if (!found && pend[IDX_W'(idx)]) begin
        found = 1'b1;
        pick  = IDX_W'(idx);
      end
    end
  end

  assign valid = lock || found;
  assign src   = lock ? lock_idx : pick;
  assign hs    = valid && ready;

  always_comb begin
    clr = '0;
    if (hs) clr[src] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= '0;
      ptr      <= IDX_W'(NUM_SRC - 1);
      lock     <= 1'b0;
      lock_idx <= '0;
    end else begin
      pend     <= (pend & ~clr) | set_vec;
      lock     <= valid && !ready;
      lock_idx <= src;
      if (hs) ptr <= src;
    end
  end

  assert_notify_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> (valid && src == $past(src)));

  assert_grant_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid |-> pend[src]);

endmodule

// File: rtl/pq_source_bank.sv
module pq_source_bank
  import pq_pkg::*;
#(
  parameter int                 NUM_SRC    = 8,
  parameter int                 PAGE_SHIFT = 13,
  parameter bit                 TWO_PAGE   = 1'b1,
  parameter int                 DATA_W     = 64,
  parameter logic [NUM_SRC-1:0] LEVEL_MASK = '0
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NUM_SRC-1:0]                  trig_in,
  input  logic                                req_valid,
  output logic                                req_ready,
  input  logic                                req_write,
  input  logic [PAGE_SHIFT+$clog2(NUM_SRC):0] req_addr,
  input  logic [1:0]                          req_size,
  output logic                                rsp_valid,
  input  logic                                rsp_ready,
  output logic [DATA_W-1:0]                   rsp_data,
  output logic                                notify_valid,
  input  logic                                notify_ready,
  output logic [$clog2(NUM_SRC)-1:0]          notify_src
);
  localparam int IDX_W = $clog2(NUM_SRC);

  logic [IDX_W-1:0]   dec_src;
  acc_op_e            dec_op;
  logic [1:0]         dec_set;
  logic               acc_fire;
  logic               acc_ok;
  logic [1:0]         pq_all [NUM_SRC];
  logic [NUM_SRC-1:0] notify_vec;
  logic [1:0]         old_pq;
  logic [DATA_W-1:0]  rsp_next;

  assign req_ready = !rsp_valid || rsp_ready;
  assign acc_fire  = req_valid && req_ready;
  assign acc_ok    = dec_op != ACC_BAD;

  pq_decode #(
    .NUM_SRC   (NUM_SRC),
    .PAGE_SHIFT(PAGE_SHIFT),
    .TWO_PAGE  (TWO_PAGE)
  ) u_dec (
    .addr   (req_addr),
    .write  (req_write),
    .size   (req_size),
    .src    (dec_src),
    .op     (dec_op),
    .set_val(dec_set)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    pq_cell #(
      .LEVEL(LEVEL_MASK[g])
    ) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .hw_in     (trig_in[g]),
      .acc_en    (acc_fire && acc_ok && (dec_src == IDX_W'(g))),
      .acc_op    (dec_op),
      .acc_set   (dec_set),
      .pq        (pq_all[g]),
      .notify_req(notify_vec[g])
    );
  end

  pq_notify_arb #(
    .NUM_SRC(NUM_SRC)
  ) u_arb (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_vec(notify_vec),
    .ready  (notify_ready),
    .valid  (notify_valid),
    .src    (notify_src)
  );

  assign old_pq = pq_all[dec_src];

  always_comb begin
    case (dec_op)
      ACC_BAD:  rsp_next = '1;
      ACC_TRIG: rsp_next = '0;
      default:  rsp_next = {{(DATA_W-2){1'b0}}, old_pq};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else if (acc_fire) begin
      rsp_valid <= 1'b1;
      rsp_data  <= rsp_next;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  assert_rsp_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  assert_one_rsp_R10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_fire |=> rsp_valid);

  assert_bad_ones_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && dec_op == ACC_BAD) |=> (rsp_data == '1));

  assert_store_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_fire && dec_op == ACC_TRIG) |=> (rsp_data == '0));

endmodule

// File: tb/sim_pq_source_bank.sv
`timescale 1ns/100ps
module sim_pq_source_bank;
  localparam int N  = 8;
  localparam int SH = 13;
  localparam logic [N-1:0] LM = 8'hC0;
  localparam int AW = SH + 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  trig_in = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd3;
  logic          rsp_ready = 1'b1, notify_ready = 1'b1;
  logic          req_ready, rsp_valid, notify_valid;
  logic [63:0]   rsp_data;
  logic [2:0]    notify_src;

  pq_source_bank #(.NUM_SRC(N), .PAGE_SHIFT(SH), .TWO_PAGE(1'b1), .LEVEL_MASK(LM)) u0 (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .notify_valid(notify_valid),
    .notify_ready(notify_ready), .notify_src(notify_src));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  string cur_tag = "R1";

  // next-cycle stimulus
  logic          nx_rst = 1'b0;
  logic [N-1:0]  nx_trig = '0;
  logic          nx_rv = 1'b0, nx_wr = 1'b0, nx_rspr = 1'b1, nx_ntr = 1'b1;
  logic [AW-1:0] nx_addr = '0;
  logic [1:0]    nx_size = 2'd3;

  // reference model
  int          m_pq [N];
  bit          m_pend [N];
  bit          m_tprev [N];
  int          m_ptr, m_lidx;
  bit          m_lock, m_rv;
  logic [63:0] m_rd;

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit m_valid();
    bit v = m_lock;
    for (int i = 0; i < N; i++) v |= m_pend[i];
    return v;
  endfunction

  function automatic int m_grant();
    if (m_lock) return m_lidx;
    for (int k = 1; k <= N; k++) begin
      int idx = (m_ptr + k) % N;
      if (m_pend[idx]) return idx;
    end
    return m_ptr;
  endfunction

  task automatic m_reset();
    for (int i = 0; i < N; i++) begin
      m_pq[i] = 0; m_pend[i] = 0; m_tprev[i] = 0;
    end
    m_ptr = N - 1; m_lidx = 0; m_lock = 0; m_rv = 0; m_rd = '0;
  endtask

  task automatic m_update();
    bit nv = m_valid();
    int g = m_grant();
    bit hs = nv && notify_ready;
    bit acc = req_valid && (!m_rv || rsp_ready);
    int src = int'(req_addr >> SH);
    int off = int'(req_addr) & 'h1FFF;
    int half = (off >> 12) & 1;
    int sel = (off >> 8) & 15;
    int op = 0;  // 0 bad 1 trig 2 eoi 3 read 4 set
    bit nset [N];
    logic [63:0] val;
    if (req_size == 2'd3 && src < N && (off & 7) == 0) begin
      if (req_write) begin
        if (half == 0) op = 1;
      end else if (half == 1 && (off & 'hF8) == 0) begin
        if (sel < 4) op = 2;
        else if (sel >= 8 && sel < 12) op = 3;
        else if (sel >= 12) op = 4;
      end
    end
    if (op == 0) val = '1;
    else if (op == 1) val = '0;
    else val = 64'(m_pq[src]);
    for (int s = 0; s < N; s++) begin
      int p = m_pq[s];
      bit t = trig_in[s] && !m_tprev[s];
      bit nt = 0;
      if (acc && op != 0 && src == s) begin
        if (op == 1) t = 1;
        else if (op == 2) begin
          if ((p & 1) != 0 || (LM[s] && trig_in[s])) begin p = 2; nt = 1; end
          else p = 0;
        end else if (op == 4) p = sel & 3;
      end
      if (t) begin
        if (p == 0) begin p = 2; nt = 1; end
        else p = 3;
      end
      m_pq[s] = p; nset[s] = nt;
      m_tprev[s] = trig_in[s];
    end
    if (hs) m_pend[g] = 0;
    for (int s = 0; s < N; s++) if (nset[s]) m_pend[s] = 1;
    m_lock = nv && !notify_ready;
    m_lidx = g;
    if (hs) m_ptr = g;
    if (acc) begin m_rv = 1; m_rd = val; end
    else if (rsp_ready) m_rv = 0;
  endtask

  task automatic compare();
    chk(notify_valid == m_valid(), "R9 notify_valid", 64'(notify_valid), 64'(m_valid()));
    if (notify_valid && m_valid())
      chk(int'(notify_src) == m_grant(), "R9 notify_src", 64'(notify_src), 64'(m_grant()));
    chk(rsp_valid == m_rv, "R10 rsp_valid", 64'(rsp_valid), 64'(m_rv));
    if (rsp_valid && m_rv) chk(rsp_data == m_rd, {cur_tag, " rsp_data"}, rsp_data, m_rd);
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) compare();
    rst_n = nx_rst; trig_in = nx_trig; req_valid = nx_rv; req_write = nx_wr;
    req_addr = nx_addr; req_size = nx_size; rsp_ready = nx_rspr; notify_ready = nx_ntr;
    #1;
    if (rst_n) begin
      chk(req_ready == (!m_rv || rsp_ready), "R10 req_ready", 64'(req_ready), 64'(!m_rv || rsp_ready));
      m_update();
    end else m_reset();
  endtask

  function automatic logic [AW-1:0] mg(int s, int off);
    return AW'((s << SH) | (1 << (SH - 1)) | off);
  endfunction

  function automatic logic [AW-1:0] tg(int s);
    return AW'(s << SH);
  endfunction

  task automatic do_req(bit w, logic [AW-1:0] a, logic [1:0] sz, output logic [63:0] d);
    nx_rv = 1; nx_wr = w; nx_addr = a; nx_size = sz;
    step();
    nx_rv = 0; nx_size = 2'd3;
    step();
    d = rsp_data;
  endtask

  task automatic expect_req(bit w, logic [AW-1:0] a, logic [1:0] sz, logic [63:0] exp, string tag);
    logic [63:0] d;
    cur_tag = tag;
    do_req(w, a, sz, d);
    chk(d == exp, tag, d, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [2:0] held;
    m_reset();
    repeat (4) step();
    nx_rst = 1;
    step(); step();
    // R1 reset state
    chk(notify_valid == 0, "R1 notify idle", 64'(notify_valid), 0);
    chk(req_ready == 1, "R1 req_ready", 64'(req_ready), 1);
    expect_req(0, mg(0, 'h800), 3, 0, "R1");
    expect_req(0, mg(7, 'h800), 3, 0, "R1");
    // R5 hardware edge, R2 transitions, R12 store trigger
    nx_trig[1] = 1; step(); step();
    expect_req(0, mg(1, 'h800), 3, 2, "R2 R5");
    expect_req(1, tg(1), 3, 0, "R12");
    expect_req(0, mg(1, 'h800), 3, 3, "R2");
    // R3 end-of-interrupt
    expect_req(0, mg(1, 'h000), 3, 3, "R3");
    expect_req(0, mg(1, 'h000), 3, 2, "R3");
    expect_req(0, mg(1, 'h800), 3, 0, "R3 R5");
    nx_trig[1] = 0; step();
    // R2 masking via 01
    expect_req(0, mg(2, 'hD00), 3, 0, "R6");
    expect_req(1, tg(2), 3, 0, "R2 R12");
    chk(notify_valid == 0, "R2 masked quiet", 64'(notify_valid), 0);
    expect_req(0, mg(2, 'h800), 3, 3, "R2");
    expect_req(0, mg(2, 'hC00), 3, 3, "R6");
    // R4 level retrigger
    nx_trig[6] = 1; step(); step();
    expect_req(0, mg(6, 'h000), 3, 2, "R4");
    expect_req(0, mg(6, 'h800), 3, 2, "R4");
    nx_trig[6] = 0; step();
    expect_req(0, mg(6, 'h000), 3, 2, "R4");
    expect_req(0, mg(6, 'h800), 3, 0, "R4");
    // R7 page halves
    expect_req(0, tg(3), 3, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    expect_req(1, mg(3, 0), 3, 64'hFFFF_FFFF_FFFF_FFFF, "R7");
    expect_req(0, mg(3, 'h800), 3, 0, "R7");
    // R8 malformed
    expect_req(0, mg(0, 'hF00), 2, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    expect_req(0, mg(9, 'h800), 3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    expect_req(0, mg(0, 'hF04), 3, 64'hFFFF_FFFF_FFFF_FFFF, "R8");
    expect_req(0, mg(0, 'h400), 3, 64'hFFFF_FFFF_FFFF_FFFF, "R6");
    expect_req(0, mg(0, 'h800), 3, 0, "R8");
    // R6 forced values
    expect_req(0, mg(5, 'hE00), 3, 0, "R6");
    expect_req(0, mg(5, 'hF00), 3, 2, "R6");
    expect_req(0, mg(5, 'h800), 3, 3, "R6");
    expect_req(0, mg(5, 'hC00), 3, 3, "R6");
    // R11 same-cycle access then trigger
    expect_req(0, mg(4, 'hF00), 3, 0, "R11");
    nx_trig[4] = 1;
    expect_req(0, mg(4, 'hC00), 3, 3, "R11");
    expect_req(0, mg(4, 'h800), 3, 2, "R11");
    expect_req(0, mg(4, 'h000), 3, 2, "R11");
    nx_trig[4] = 0; step();
    // R9 stall and round robin
    cur_tag = "R9";
    nx_ntr = 0; nx_trig = 8'b0010_0101; step(); step();
    chk(notify_valid == 1, "R9 stall valid", 64'(notify_valid), 1);
    held = notify_src;
    step(); step(); step();
    chk(notify_src == held, "R9 stall hold", 64'(notify_src), 64'(held));
    nx_ntr = 1; nx_trig = '0;
    repeat (5) step();
    chk(notify_valid == 0, "R9 drained", 64'(notify_valid), 0);
    expect_req(0, mg(0, 'h000), 3, 2, "R9");
    expect_req(0, mg(2, 'h000), 3, 2, "R9");
    expect_req(0, mg(5, 'h000), 3, 2, "R9");
    // R10 response stall
    cur_tag = "R10";
    nx_rspr = 0; nx_rv = 1; nx_wr = 0; nx_addr = mg(5, 'h800); step();
    nx_rv = 0; step(); step();
    chk(rsp_valid == 1, "R10 held valid", 64'(rsp_valid), 1);
    chk(req_ready == 0, "R10 blocked", 64'(req_ready), 0);
    chk(rsp_data == 0, "R10 held data", rsp_data, 0);
    nx_rspr = 1; step(); step();
    // random phase against the model
    cur_tag = "R2 R3 R4 R6 R8 R11 random";
    for (int c = 0; c < 4000; c++) begin
      nx_ntr  = ($urandom % 4) != 0;
      nx_rspr = ($urandom % 4) != 0;
      for (int s = 0; s < N; s++) if ($urandom % 10 == 0) nx_trig[s] = ~nx_trig[s];
      nx_rv = ($urandom % 5) < 2;
      nx_wr = ($urandom % 4) == 0;
      nx_size = ($urandom % 16 == 0) ? 2'd2 : 2'd3;
      nx_addr = AW'((($urandom % 10) << SH) | (($urandom % 2) << (SH - 1)) |
                    (($urandom % 16) << 8) | (($urandom % 12 == 0) ? 8 : 0));
      step();
    end
    nx_rv = 0; nx_rspr = 1; nx_ntr = 1;
    repeat (20) step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule